// File: doc/BRIEF.md
# DMA Hold-Acknowledge Arbiter

This block decides when a DMA controller may take over the system bus from the CPU. On every rising clock edge it looks at the CPU bus-status lines, the CPU bus-lock line, the DMA controller's hold request and a write strobe with its I/O address. From these it forms a grant term. The first stage of a short flip-flop pipeline captures that term. Once the term is captured, the pipeline passes it stage by stage to the hold-acknowledge output. From the moment the grant is captured until one cycle after hold acknowledge drops, the block holds the CPU in wait states by pulling its ready line low.

Normally a grant is taken only in an idle CPU bus cycle with no bus lock in force. There is one exception. If the CPU is itself writing to the DMA controller's register range while a hold request is pending, the grant term is forced true. This stops the deadlock in which the CPU waits on a controller that is waiting on the CPU. The forced term changes timing only on cycles that write to that register range.

The reset input is asynchronous and active low. It is released synchronously to the clock inside the block.

Top module: `dma_hold_arbiter`

## Requirements
- R1: While reset is in force, and on the first edges after it is released with no request, `hold_ack` is 0 and `cpu_ready` is 1.
- R2: Status `cpu_stat_n` = 3'b111 marks an idle bus cycle. If a rising edge k sees an idle status, `bus_lock_n` = 1 and `dma_hreq` = 1, the grant is captured at edge k and `hold_ack` is 1 after edge k+2.
- R3: Any status other than 3'b111 withholds the grant, unless R5 applies.
- R4: An active bus lock (`bus_lock_n` = 0) withholds the grant, even in an idle status, unless R5 applies.
- R5: While `dma_hreq` = 1, an I/O write (`io_wr_n` = 0) to an address in 0x00..0x1F forces the grant term true, whatever the status and lock. Both ends of the range are included.
- R6: An I/O write to an address outside 0x00..0x1F (for example 0x20) does not force the grant term.
- R7: While `dma_hreq` = 0, no grant is captured, even during a write to the DMA range.
- R8: `cpu_ready` is 0 from the edge that captures the grant until one edge after `hold_ack` falls. It then returns to 1 unless a new grant has been captured.
- R9: A captured grant holds while `dma_hreq` stays 1, whatever the status and lock. `hold_ack` is 0 after the first edge that samples `dma_hreq` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every stage uses its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cpu_stat_n | input | 3 | Active-low CPU bus-status lines; 3'b111 marks an idle cycle |
| bus_lock_n | input | 1 | Active-low CPU bus lock |
| dma_hreq | input | 1 | Hold request from the DMA controller |
| io_wr_n | input | 1 | Active-low CPU I/O write strobe |
| io_addr | input | 10 | CPU I/O address |
| hold_ack | output | 1 | Hold acknowledge to the DMA controller |
| cpu_ready | output | 1 | CPU ready; 0 inserts wait states |

## Verification
A wrong internal state shows at the ports within three edges. A stage that is lost or stuck makes `hold_ack` rise too early, too late or never, measured from the edge that captured the grant. A grant that is not held makes `hold_ack` drop while `dma_hreq` is still high. A bad wait register makes `cpu_ready` disagree with the capture edge, or with the single edge that follows the fall of `hold_ack`. A faulty address decode shows in the first write cycle at 0x10, 0x1F or 0x20 with a request pending, as a grant that is missing or taken when it should not be.

// File: rtl/dha_pkg.sv
package dha_pkg;
  localparam int STAT_W = 3;

  typedef enum logic [STAT_W-1:0] {
    ST_INTA  = 3'b000,
    ST_IORD  = 3'b001,
    ST_IOWR  = 3'b010,
    ST_HALT  = 3'b011,
    ST_CODE  = 3'b100,
    ST_MEMRD = 3'b101,
    ST_MEMWR = 3'b110,
    ST_IDLE  = 3'b111
  } bus_stat_e;

  function automatic logic stat_is_idle(input logic [STAT_W-1:0] s);
    return bus_stat_e'(s) == ST_IDLE;
  endfunction
endpackage

// File: rtl/dha_reset_sync.sv
module dha_reset_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[LAST-1:0], 1'b1};
  end

  assign rst_q_n = chain_q[LAST];
endmodule

// File: rtl/dha_port_decode.sv
module dha_port_decode #(
  parameter int ADDR_W   = 10,
  parameter int DMA_BASE = 0,
  parameter int DMA_SPAN = 32
) (
  input  logic              io_wr_n,
  input  logic [ADDR_W-1:0] io_addr,
  output logic              dma_wr_hit
);
  localparam logic [ADDR_W-1:0] SPAN_MASK = ADDR_W'(DMA_SPAN - 1);
  localparam logic [ADDR_W-1:0] BASE_VEC  = ADDR_W'(DMA_BASE);

  logic in_range;

  always_comb begin
    in_range   = (io_addr & ~SPAN_MASK) == (BASE_VEC & ~SPAN_MASK);
    dma_wr_hit = in_range && !io_wr_n;
  end
endmodule

// File: rtl/dha_grant_term.sv
module dha_grant_term
  import dha_pkg::*;
(
  input  logic              dma_hreq,
  input  logic [STAT_W-1:0] cpu_stat_n,
  input  logic              bus_lock_n,
  input  logic              dma_wr_hit,
  output logic              grant_term
);
  logic idle_slot;

  always_comb begin
    idle_slot  = stat_is_idle(cpu_stat_n) && bus_lock_n && dma_hreq;
    grant_term = idle_slot || (dma_wr_hit && dma_hreq);
  end
endmodule

// File: rtl/dha_ack_pipe.sv
module dha_ack_pipe #(
  parameter int ACK_STAGES = 3
) (
  input  logic clk,
  input  logic rst_q_n,
  input  logic dma_hreq,
  input  logic grant_term,
  output logic grant_cap,
  output logic hold_ack,
  output logic wait_req
);
  localparam int LAST = ACK_STAGES - 1;

  logic [LAST:0] stage_q, stage_d;
  logic          wait_q, wait_d;
  logic          stage_en;

  assign stage_en = 1'b1;

  always_comb begin
    stage_d[0] = dma_hreq && (grant_term || stage_q[0]);
  end

  for (genvar g = 1; g <= LAST; g++) begin : g_stage
    always_comb stage_d[g] = dma_hreq && stage_q[g-1];

    p_stage_order_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
      stage_q[g] |-> $past(stage_q[g-1]));
  end

  always_comb wait_d = stage_d[0] || stage_q[LAST];

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      stage_q <= '0;
      wait_q  <= 1'b0;
    end else if (stage_en) begin
      stage_q <= stage_d;
      wait_q  <= wait_d;
    end
  end

  assign grant_cap = stage_q[0];
  assign hold_ack  = stage_q[LAST];
  assign wait_req  = wait_q;

  p_drop_on_release_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !dma_hreq |=> !hold_ack);

  p_ack_waits_cpu_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    hold_ack |-> wait_req);

  p_wait_tail_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    $fell(hold_ack) |-> wait_req);
endmodule

// File: rtl/dma_hold_arbiter.sv
module dma_hold_arbiter
  import dha_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DMA_BASE   = 0,
  parameter int DMA_SPAN   = 32,
  parameter int ACK_STAGES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cpu_stat_n,
  input  logic              bus_lock_n,
  input  logic              dma_hreq,
  input  logic              io_wr_n,
  input  logic [ADDR_W-1:0] io_addr,
  output logic              hold_ack,
  output logic              cpu_ready
);
  logic rst_q_n;
  logic dma_wr_hit;
  logic grant_term;
  logic grant_cap;
  logic wait_req;

  dha_reset_sync #(.SYNC_STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  dha_port_decode #(
    .ADDR_W   (ADDR_W),
    .DMA_BASE (DMA_BASE),
    .DMA_SPAN (DMA_SPAN)
  ) u_dec (
    .io_wr_n    (io_wr_n),
    .io_addr    (io_addr),
    .dma_wr_hit (dma_wr_hit)
  );

  dha_grant_term u_term (
    .dma_hreq   (dma_hreq),
    .cpu_stat_n (cpu_stat_n),
    .bus_lock_n (bus_lock_n),
    .dma_wr_hit (dma_wr_hit),
    .grant_term (grant_term)
  );

  dha_ack_pipe #(.ACK_STAGES(ACK_STAGES)) u_pipe (
    .clk        (clk),
    .rst_q_n    (rst_q_n),
    .dma_hreq   (dma_hreq),
    .grant_term (grant_term),
    .grant_cap  (grant_cap),
    .hold_ack   (hold_ack),
    .wait_req   (wait_req)
  );

  assign cpu_ready = !wait_req;

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_q_n |-> (!hold_ack && cpu_ready));

  p_busy_stat_blocks_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!grant_cap && !stat_is_idle(cpu_stat_n) && !dma_wr_hit) |=> !grant_cap);

  p_lock_blocks_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!grant_cap && !bus_lock_n && !dma_wr_hit) |=> !grant_cap);

  p_write_forces_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (dma_hreq && dma_wr_hit) |=> grant_cap);

  p_no_req_no_grant_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    !dma_hreq |=> (!grant_cap && !hold_ack));
endmodule

// File: tb/dma_hold_arbiter_tb.sv
module dma_hold_arbiter_tb;
  localparam time TCK = 20ns;

  typedef struct {
    logic  ack;
    logic  rdy;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] cpu_stat_n;
  logic       bus_lock_n;
  logic       dma_hreq;
  logic       io_wr_n;
  logic [9:0] io_addr;
  logic       hold_ack;
  logic       cpu_ready;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;

  int   m_cnt = 0;
  logic m_ack = 1'b0;
  logic m_wt  = 1'b0;

  always #(TCK/2) clk = ~clk;

  dma_hold_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_stat_n(cpu_stat_n), .bus_lock_n(bus_lock_n),
    .dma_hreq(dma_hreq), .io_wr_n(io_wr_n), .io_addr(io_addr),
    .hold_ack(hold_ack), .cpu_ready(cpu_ready)
  );

  // Drive one cycle of inputs, then predict the outputs after the edge
  task automatic step(input logic [2:0] st, input logic lk, input logic rq,
                      input logic wr, input logic [9:0] ad, input string tag);
    logic term, prev_ack;
    exp_t e;
    @(negedge clk);
    #2;
    cpu_stat_n = st; bus_lock_n = lk; dma_hreq = rq; io_wr_n = wr; io_addr = ad;
    @(posedge clk);
    term = rq && ((st == 3'b111 && lk) || (!wr && ad < 10'h20));
    prev_ack = m_ack;
    if (!rq) m_cnt = 0;
    else if (m_cnt != 0 || term) m_cnt = (m_cnt < 3) ? m_cnt + 1 : 3;
    m_ack = (m_cnt == 3);
    m_wt  = (m_cnt != 0) || prev_ack;
    e.ack = m_ack; e.rdy = !m_wt; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(3'b111, 1'b1, 1'b0, 1'b1, 10'h000, tag);
  endtask

  // Monitor: compare at the falling edge
  always @(negedge clk) begin
    if (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (hold_ack !== e.ack || cpu_ready !== e.rdy) begin
        n_bad++;
        $display("FAIL %s: hold_ack=%b cpu_ready=%b expected hold_ack=%b cpu_ready=%b",
                 e.tag, hold_ack, cpu_ready, e.ack, e.rdy);
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    cpu_stat_n = 3'b111; bus_lock_n = 1'b1; dma_hreq = 1'b0;
    io_wr_n = 1'b1; io_addr = '0;
    repeat (3) @(negedge clk);
    n_cmp++;
    if (hold_ack !== 1'b0 || cpu_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R1 in reset: hold_ack=%b cpu_ready=%b expected 0 1", hold_ack, cpu_ready);
    end
    rst_n = 1'b1;
    idle(4, "R1 after reset");

    // R4: request during a locked idle cycle
    for (int i = 0; i < 5; i++) step(3'b111, 1'b0, 1'b1, 1'b1, 10'h000, "R4 locked");
    idle(2, "R4 flush");

    // R3: request during busy status codes
    for (int i = 0; i < 5; i++) step(3'b101, 1'b1, 1'b1, 1'b1, 10'h000, "R3 busy status");
    step(3'b011, 1'b1, 1'b1, 1'b1, 10'h000, "R3 busy status");
    idle(2, "R3 flush");

    // R2/R8/R9: grant in an idle cycle, held through busy status, then released
    for (int i = 0; i < 4; i++) step(3'b111, 1'b1, 1'b1, 1'b1, 10'h000, "R2 idle grant");
    for (int i = 0; i < 3; i++) step(3'b100, 1'b0, 1'b1, 1'b1, 10'h000, "R9 grant held");
    step(3'b111, 1'b1, 1'b0, 1'b1, 10'h000, "R9 release");
    step(3'b111, 1'b1, 1'b0, 1'b1, 10'h000, "R8 ready tail");
    idle(2, "R8 ready back");

    // R5: CPU write to port 0x10 forces the grant
    for (int i = 0; i < 4; i++) step(3'b110, 1'b1, 1'b1, 1'b0, 10'h010, "R5 write 0x10");
    idle(3, "R5 flush");
    // R5: upper edge 0x1F and lock active
    for (int i = 0; i < 4; i++) step(3'b010, 1'b0, 1'b1, 1'b0, 10'h01F, "R5 write 0x1F");
    idle(3, "R5 flush");

    // R6: write just outside the range
    for (int i = 0; i < 4; i++) step(3'b010, 1'b1, 1'b1, 1'b0, 10'h020, "R6 write 0x20");
    idle(2, "R6 flush");

    // R7: DMA-range write with no request
    for (int i = 0; i < 4; i++) step(3'b010, 1'b1, 1'b0, 1'b0, 10'h010, "R7 no request");
    idle(2, "R7 flush");

    // R8: back-to-back request right after release
    for (int i = 0; i < 4; i++) step(3'b111, 1'b1, 1'b1, 1'b1, 10'h000, "R8 second grant");
    step(3'b111, 1'b1, 1'b0, 1'b1, 10'h000, "R8 drop");
    step(3'b111, 1'b1, 1'b1, 1'b1, 10'h000, "R8 regrant");
    step(3'b111, 1'b1, 1'b1, 1'b1, 10'h000, "R8 regrant");
    idle(4, "R8 flush");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(TCK * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule